// File: doc/BRIEF.md
# Serial ADC Conversion Read Controller

This block is an SPI master that performs a single conversion read from a multi-channel 12-bit successive-approximation converter with a serial port. When a start request arrives, it captures the channel number, the single-ended/differential choice and a clock divider setting. It pulls chip select low and runs 24 serial clocks, grouped as three byte-aligned segments. The serial clock idles high. The command goes out on the data-in line and changes only on falling clock edges. The converter's reply is sampled on rising clock edges.

The command frame starts with five zero bits. Then come a start bit, the mode bit and the three channel bits, and the rest of the frame is zero. The reply has a null bit, which should be zero, and then twelve result bits, most significant first. These are the last thirteen bits of the frame. When chip select returns high, the block presents the 12-bit result with a one-cycle valid strobe and a flag that reports a bad null bit.

The rate of the serial clock comes from a divider. The block holds the divider between a fixed lower limit and an upper limit that keeps the whole transfer fast enough for the converter's hold capacitor.

Top module: `adc_read_ctrl`

## Requirements
- R1: After reset and whenever no transfer is running, chip select is high, the serial clock is high, data-in is low, busy is low and valid is low.
- R2: The half-period of the serial clock, in system clocks, is the `half_div_i` value sampled with the accepted start. Values below 2 are raised to 2. Values above MAX_HALF = CLK_HZ / (2 * MIN_SCLK_HZ) are lowered to MAX_HALF.
- R3: A transfer lasts exactly 50 half-periods with chip select low, in this order:
  - one half-period with the serial clock high;
  - 24 clock periods, each a low half followed by a high half;
  - one more half-period with the serial clock high.
- R4: Data-in changes only at falling clock edges. On falling edge k (k = 0..23), it carries command bit k. The command is: bits 0..4 = 0, bit 5 = 1, bit 6 = `sgl_i`, bits 7, 8, 9 = `chan_i[2]`, `chan_i[1]`, `chan_i[0]`, bits 10..23 = 0.
- R5: Data-out is sampled at each rising edge. `result_o` is the 12 bits sampled at rising edges 12..23, with edge 12 as bit 11 and edge 23 as bit 0.
- R6: `null_err_o` is 1 exactly when the bit sampled at rising edge 11 was 1. It updates together with `result_o`.
- R7: `valid_o` is high for exactly one system clock, in the first cycle that chip select is high again. `busy_o` is high from the cycle after the accepted start through the last cycle with chip select low.
- R8: A start request while busy is high is ignored. A start request in the cycle where valid is high is accepted.
- R9: `result_o` and `null_err_o` keep their values from one completion to the next. Both are 0 after reset.
- R10: The bits received at rising edges 0..10 have no effect on `result_o` or `null_err_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request one conversion read |
| sgl_i | input | 1 | 1 = single-ended input, 0 = differential pair |
| chan_i | input | 3 | Channel select, sent MSB first |
| half_div_i | input | DIV_W | Serial clock half-period in system clocks |
| dout_i | input | 1 | Serial data from the converter |
| cs_n_o | output | 1 | Chip select, active low |
| sclk_o | output | 1 | Serial clock, idles high |
| din_o | output | 1 | Serial command to the converter |
| busy_o | output | 1 | Transfer in progress |
| valid_o | output | 1 | One-cycle strobe marking a new result |
| result_o | output | 12 | Last conversion result |
| null_err_o | output | 1 | Null bit of the last transfer was not 0 |

## Verification
The reads cover several channel and mode pairs, so a swapped, shifted or dropped command bit shows up as a data-in mismatch at a particular falling edge. The converter model returns all-zero, all-one and mixed result words and drives ones during the don't-care window. This separates a correct 12-bit capture window from one that is off by a bit or that lets early bits leak in. Divider settings of 0, 2, 3 and 4 and one above the upper limit check the clamping and the length of every phase. Other reads add an injected null-bit error, start pulses that arrive during a transfer, and a start held high over two back-to-back transfers, to test the acceptance rules.

// File: rtl/adcrd_pkg.sv
package adcrd_pkg;

    localparam int FRAME_LEN  = 24;
    localparam int RES_W      = 12;
    localparam int NULL_SLOT  = 11;
    localparam int IDX_W      = $clog2(FRAME_LEN + 1);
    localparam int START_SLOT = 5;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SETUP,
        PH_LOW,
        PH_HIGH,
        PH_HOLD
    } phase_e;

endpackage

// File: rtl/adcrd_halftick.sv
module adcrd_halftick #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [DIV_W-1:0] half_i,
    output logic             tick_o
);
    logic [DIV_W-1:0] cnt_d, cnt_q;
    logic             tick;

    always_comb begin
        tick  = run_i && (cnt_q == half_i - 1'b1);
        cnt_d = cnt_q;
        if (!run_i || tick) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign tick_o = tick;
endmodule

// File: rtl/adcrd_cmdword.sv
module adcrd_cmdword
    import adcrd_pkg::*;
(
    input  logic                 sgl_i,
    input  logic [2:0]           chan_i,
    output logic [FRAME_LEN-1:0] cmd_o
);
    // Slot k of the frame is held in bit FRAME_LEN-1-k.
    always_comb begin
        cmd_o = '0;
        cmd_o[FRAME_LEN-1-START_SLOT]     = 1'b1;
        cmd_o[FRAME_LEN-1-(START_SLOT+1)] = sgl_i;
        for (int i = 0; i < 3; i++) begin
            cmd_o[FRAME_LEN-1-(START_SLOT+2+i)] = chan_i[2-i];
        end
    end
endmodule

// File: rtl/adc_read_ctrl.sv
module adc_read_ctrl
    import adcrd_pkg::*;
#(
    parameter int CLK_HZ      = 100_000_000,
    parameter int MIN_SCLK_HZ = 10_000,
    parameter int DIV_W       = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             sgl_i,
    input  logic [2:0]       chan_i,
    input  logic [DIV_W-1:0] half_div_i,
    input  logic             dout_i,
    output logic             cs_n_o,
    output logic             sclk_o,
    output logic             din_o,
    output logic             busy_o,
    output logic             valid_o,
    output logic [11:0]      result_o,
    output logic             null_err_o
);
    localparam int MAX_HALF_RAW = CLK_HZ / (2 * MIN_SCLK_HZ);
    localparam int MAX_HALF     = (MAX_HALF_RAW < 2) ? 2 : MAX_HALF_RAW;
    localparam logic [DIV_W-1:0] HALF_HI = DIV_W'(MAX_HALF);
    localparam logic [DIV_W-1:0] HALF_LO = DIV_W'(2);

    typedef struct packed {
        phase_e               ph;
        logic [DIV_W-1:0]     half;
        logic [FRAME_LEN-1:0] cmd;
        logic [FRAME_LEN-1:0] rx;
        logic [IDX_W-1:0]     idx;
        logic                 cs_n;
        logic                 sclk;
        logic                 din;
        logic                 valid;
        logic                 err;
        logic [RES_W-1:0]     res;
    } state_t;

    state_t               s_d, s_q;
    logic                 tick;
    logic [FRAME_LEN-1:0] cmd_w;
    logic [DIV_W-1:0]     half_eff;

    adcrd_cmdword u_cmd (
        .sgl_i  (sgl_i),
        .chan_i (chan_i),
        .cmd_o  (cmd_w)
    );

    adcrd_halftick #(.DIV_W(DIV_W)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (s_q.ph != PH_IDLE),
        .half_i (s_q.half),
        .tick_o (tick)
    );

    always_comb begin
        if (half_div_i < HALF_LO)      half_eff = HALF_LO;
        else if (half_div_i > HALF_HI) half_eff = HALF_HI;
        else                           half_eff = half_div_i;
    end

    always_comb begin
        s_d       = s_q;
        s_d.valid = 1'b0;
        unique case (s_q.ph)
            PH_IDLE: begin
                s_d.cs_n = 1'b1;
                s_d.sclk = 1'b1;
                s_d.din  = 1'b0;
                if (start_i) begin
                    s_d.ph   = PH_SETUP;
                    s_d.cs_n = 1'b0;
                    s_d.half = half_eff;
                    s_d.cmd  = cmd_w;
                    s_d.rx   = '0;
                    s_d.idx  = '0;
                end
            end
            PH_SETUP, PH_HIGH: begin
                if (tick) begin
                    if (s_q.idx == IDX_W'(FRAME_LEN)) begin
                        s_d.ph = PH_HOLD;
                    end else begin
                        s_d.ph   = PH_LOW;
                        s_d.sclk = 1'b0;
                        s_d.din  = s_q.cmd[FRAME_LEN-1];
                        s_d.cmd  = {s_q.cmd[FRAME_LEN-2:0], 1'b0};
                    end
                end
            end
            PH_LOW: begin
                if (tick) begin
                    s_d.ph   = PH_HIGH;
                    s_d.sclk = 1'b1;
                    s_d.rx   = {s_q.rx[FRAME_LEN-2:0], dout_i};
                    s_d.idx  = s_q.idx + 1'b1;
                end
            end
            PH_HOLD: begin
                if (tick) begin
                    s_d.ph    = PH_IDLE;
                    s_d.cs_n  = 1'b1;
                    s_d.din   = 1'b0;
                    s_d.valid = 1'b1;
                    s_d.res   = s_q.rx[RES_W-1:0];
                    s_d.err   = s_q.rx[FRAME_LEN-1-NULL_SLOT];
                end
            end
            default: s_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.ph   <= PH_IDLE;
            s_q.half <= HALF_LO;
            s_q.cs_n <= 1'b1;
            s_q.sclk <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign cs_n_o     = s_q.cs_n;
    assign sclk_o     = s_q.sclk;
    assign din_o      = s_q.din;
    assign busy_o     = (s_q.ph != PH_IDLE);
    assign valid_o    = s_q.valid;
    assign result_o   = s_q.res;
    assign null_err_o = s_q.err;
endmodule

// File: rtl/adcrd_checker.sv
module adcrd_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        cs_n_o,
    input logic        sclk_o,
    input logic        din_o,
    input logic        busy_o,
    input logic        valid_o,
    input logic [11:0] result_o,
    input logic        null_err_o
);
    p_idle_lines_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (cs_n_o && sclk_o));

    p_sclk_low_inside_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !sclk_o |-> !cs_n_o);

    p_din_on_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n_o && $past(!cs_n_o) && !$stable(din_o)) |-> $fell(sclk_o));

    p_valid_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    p_valid_on_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> ($rose(cs_n_o) && !busy_o));

    p_busy_tracks_cs_r7: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o == !cs_n_o);

    p_result_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> ($stable(result_o) && $stable(null_err_o)));
endmodule

bind adc_read_ctrl adcrd_checker u_adcrd_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_n_o     (cs_n_o),
    .sclk_o     (sclk_o),
    .din_o      (din_o),
    .busy_o     (busy_o),
    .valid_o    (valid_o),
    .result_o   (result_o),
    .null_err_o (null_err_o)
);

// File: tb/adc_read_ctrl_bench.sv
`timescale 1ns/1ps
module adc_read_ctrl_bench;
    localparam int CLK_HZ = 400_000;
    localparam int MAXH   = CLK_HZ / 20_000;   // 20

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        sgl_i = 1'b0;
    logic [2:0]  chan_i = '0;
    logic [15:0] half_div_i = 16'd2;
    logic        dout_i = 1'b1;
    logic        cs_n_o, sclk_o, din_o, busy_o, valid_o, null_err_o;
    logic [11:0] result_o;

    always #5 clk = ~clk;

    adc_read_ctrl #(.CLK_HZ(CLK_HZ), .MIN_SCLK_HZ(10_000), .DIV_W(16)) u_adc_read_ctrl (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .sgl_i(sgl_i), .chan_i(chan_i),
        .half_div_i(half_div_i), .dout_i(dout_i), .cs_n_o(cs_n_o), .sclk_o(sclk_o),
        .din_o(din_o), .busy_o(busy_o), .valid_o(valid_o), .result_o(result_o),
        .null_err_o(null_err_o)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s act=%0h exp=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    // ---------------- behavioural converter ----------------
    logic [11:0] resp_val = '0;
    bit          resp_bad = 0;
    int          fall_n = 0, rise_n = 0;
    logic [23:0] din_seen = '0;

    always @(negedge cs_n_o) begin
        fall_n = 0;
        rise_n = 0;
        dout_i = 1'b1;
    end
    always @(negedge sclk_o) if (!cs_n_o) begin
        // slots 0..10 are don't-care (driven 1), 11 is the null bit
        if (fall_n < 11)       dout_i = 1'b1;
        else if (fall_n == 11) dout_i = resp_bad;
        else if (fall_n < 24)  dout_i = resp_val[23 - fall_n];
        fall_n++;
    end
    always @(posedge sclk_o) if (!cs_n_o && rise_n < 24) begin
        din_seen[23 - rise_n] = din_o;
        rise_n++;
    end

    // ---------------- cycle reference model ----------------
    bit          m_busy = 0, m_valid = 0;
    int          m_off = 0, m_h = 2;
    logic [23:0] m_cmd = '0;
    logic [11:0] m_res = '0, e_res = '0;
    bit          m_err = 0, e_err = 0;

    function automatic logic [23:0] build_cmd(bit s, logic [2:0] c);
        logic [23:0] w = '0;
        w[23-5] = 1'b1;
        w[23-6] = s;
        w[23-7] = c[2];
        w[23-8] = c[1];
        w[23-9] = c[0];
        return w;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_valid = 0; m_off = 0; e_res = '0; e_err = 0;
        end else begin
            m_valid = 0;
            if (m_busy) begin
                if (m_off == 50 * m_h - 1) begin
                    m_busy = 0; m_valid = 1; e_res = m_res; e_err = m_err;
                end else begin
                    m_off++;
                end
            end else if (start_i) begin
                m_busy = 1; m_off = 0;
                m_h = (half_div_i < 2) ? 2 : ((half_div_i > MAXH) ? MAXH : int'(half_div_i));
                m_cmd = build_cmd(sgl_i, chan_i);
                m_res = resp_val; m_err = resp_bad;
            end
        end
    end

    always @(negedge clk) if (rst_n && !done) begin
        int p;
        int k;
        logic e_sclk, e_din;
        p = m_off / m_h;
        e_sclk = 1'b1; e_din = 1'b0;
        if (m_busy && p >= 1) begin
            k = (p - 1) / 2;
            if (k > 23) k = 23;
            e_din = m_cmd[23 - k];
            if (p <= 48 && (p % 2) == 1) e_sclk = 1'b0;
        end
        chk("R3", "cs_n", cs_n_o, !m_busy);
        chk("R3", "sclk", sclk_o, e_sclk);
        chk("R4", "din", din_o, e_din);
        chk("R7", "busy", busy_o, m_busy);
        chk("R7", "valid", valid_o, m_valid);
        chk("R9", "result", result_o, e_res);
        chk("R6", "null_err", null_err_o, e_err);
    end

    // ---------------- stimulus ----------------
    task automatic go(bit s, logic [2:0] c, int div, logic [11:0] val, bit bad, bit pester);
        int h;
        h = (div < 2) ? 2 : ((div > MAXH) ? MAXH : div);
        @(negedge clk);
        sgl_i = s; chan_i = c; half_div_i = 16'(div); resp_val = val; resp_bad = bad;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        if (pester) begin
            // R8: start pulses while busy with other settings must be ignored
            repeat (7) @(negedge clk);
            sgl_i = ~s; chan_i = ~c; half_div_i = 16'd3; start_i = 1'b1;
            @(negedge clk); start_i = 1'b0;
            repeat (20 * h) @(negedge clk);
            start_i = 1'b1;
            @(negedge clk); start_i = 1'b0;
            sgl_i = s; chan_i = c;
        end
        while (!valid_o) @(negedge clk);
        chk("R5", "result at valid", result_o, val);
        chk("R10", "early bits ignored", result_o, val);
        chk("R6", "null flag", null_err_o, bad);
        chk("R4", "command seen", din_seen, build_cmd(s, c));
        chk("R8", "no restart", busy_o, 0);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        chk("R1", "reset cs_n", cs_n_o, 1);
        chk("R1", "reset sclk", sclk_o, 1);
        chk("R1", "reset din", din_o, 0);
        chk("R1", "reset busy", busy_o, 0);
        chk("R9", "reset result", result_o, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1", "idle busy", busy_o, 0);

        go(1'b1, 3'd5, 2, 12'hA5C, 0, 0);
        go(1'b0, 3'd2, 3, 12'h3C1, 0, 0);
        go(1'b1, 3'd7, 0, 12'hFFF, 0, 0);   // R2 low clamp
        go(1'b0, 3'd0, 50, 12'h000, 0, 0);  // R2 high clamp
        go(1'b1, 3'd3, 4, 12'h5A5, 1, 0);   // R6 null error
        go(1'b0, 3'd6, 2, 12'h812, 0, 1);   // R8 starts while busy
        go(1'b1, 3'd1, 2, 12'h001, 0, 0);   // clears R6 flag

        // R8: start held high gives back-to-back transfers
        @(negedge clk);
        sgl_i = 1'b0; chan_i = 3'd4; half_div_i = 16'd2; resp_val = 12'h7E3; resp_bad = 0;
        start_i = 1'b1;
        while (!valid_o) @(negedge clk);
        chk("R5", "first back-to-back", result_o, 12'h7E3);
        @(negedge clk);
        chk("R8", "restart after valid", busy_o, 1);
        start_i = 1'b0;
        while (!valid_o) @(negedge clk);
        chk("R5", "second back-to-back", result_o, 12'h7E3);
        repeat (4) @(negedge clk);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog expired act=running exp=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule